// File: doc/BRIEF.md
# Transmit Queue with Free-Space Watermark Request

This block is a sixteen-slot transmit queue placed between a word producer (a processor or a DMA engine) and a serial shifter. The producer pushes words through a write port and the shifter drains them in order through a read port. A single request output tells the producer that enough of the queue is free to accept another burst. The producer selects the amount of free space that counts as enough by programming a 3-bit threshold code.

A 16-bit control word holds the threshold code, a request enable, a DMA-mode flag, two sticky error flags and a self-clearing queue flush. Reading the control word also returns a read-only free-slot count, which runs from 0 when the queue is full to 16 when it is empty. Some threshold codes are reserved, and one code is unsafe under DMA pacing. The block does not act on these settings. It falls back to the "completely empty" threshold and records the misconfiguration in a sticky flag.

Top module: `txq_watermark`

## Requirements
- R1: Words leave the read port in the order they were accepted. `rd_valid` is high exactly when the queue holds at least one word. All 16 slots can be filled whatever threshold code is programmed.
- R2: Control bits 12:8 read back the number of free slots, which is 16 minus the occupancy. Writes to these bits have no effect.
- R3: A push while the queue holds 16 words is dropped, even if a pop happens in the same cycle, and it sets the sticky overflow flag in control bit 2. Writing 1 to bit 2 clears the flag unless a new drop happens in the same cycle.
- R4: The threshold code is in control bits 15:13 and resets to 000. The free-slot count needed to request is 16 for code 000, 12 for code 100, 8 for code 101, 4 for code 110 and 1 for code 111.
- R5: Codes 001, 010 and 011 are reserved. While one of them is programmed, the block behaves as code 000 and sets the sticky configuration-error flag in control bit 3 on every cycle. Writing 1 to bit 3 clears the flag.
- R6: When DMA mode (control bit 1) is set together with code 111, the block behaves as code 000 and sets the configuration-error flag.
- R7: `xfer_req` is the request enable (control bit 0) ANDed with the comparison "free slots ≥ threshold". The output is registered, so it follows a change of occupancy or of the control fields one clock edge later.
- R8: A push and a pop in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged. A pop on an empty queue is ignored.
- R9: Writing 1 to control bit 4 empties the queue on that edge, taking priority over a push or pop in the same cycle. Bit 4 always reads as 0.
- R10: After the synchronous active-low reset, the queue is empty, `xfer_req` is low and the control word reads 16'h1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push | input | 1 | Write one word into the queue |
| wr_data | input | DW | Word to write |
| pop | input | 1 | Remove the head word |
| rd_data | output | DW | Head word of the queue |
| rd_valid | output | 1 | Queue is not empty |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Control word write value |
| reg_rdata | output | 16 | Control word read value |
| xfer_req | output | 1 | Free-space transfer request |

## Verification
Two situations are hard to reach: a drop on a full queue in the same cycle as a pop, and the request exactly at a threshold edge, such as 12 free slots under code 100. Directed steps fill the queue to exact levels, and one step pushes and pops while the queue is full. A long random phase then mixes pushes, pops, flushes and control writes, including reserved codes and DMA mode with code 111. A behavioural queue model checks every field on each clock.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned CTRL_W    = 16;
  localparam int unsigned WM_LSB    = 13;
  localparam int unsigned FREE_LSB  = 8;
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_DMA   = 1;
  localparam int unsigned BIT_OVF   = 2;
  localparam int unsigned BIT_CFG   = 3;
  localparam int unsigned BIT_FLUSH = 4;

  typedef enum logic [2:0] {
    WM_ALL   = 3'b000,
    WM_RSV_A = 3'b001,
    WM_RSV_B = 3'b010,
    WM_RSV_C = 3'b011,
    WM_3Q    = 3'b100,
    WM_HALF  = 3'b101,
    WM_1Q    = 3'b110,
    WM_ONE   = 3'b111
  } wm_code_e;

  function automatic logic code_reserved(input logic [2:0] c);
    return (c == WM_RSV_A) || (c == WM_RSV_B) || (c == WM_RSV_C);
  endfunction

  function automatic logic code_unsafe(input logic [2:0] c, input logic dma);
    return code_reserved(c) || (dma && c == WM_ONE);
  endfunction

  // free slots needed to raise the request
  function automatic int wm_threshold(input logic [2:0] c, input int depth);
    case (c)
      WM_3Q:   return (depth * 3) / 4;
      WM_HALF: return depth / 2;
      WM_1Q:   return depth / 4;
      WM_ONE:  return 1;
      default: return depth;
    endcase
  endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (level == CW'(DEPTH));
  assign empty     = (level == '0);
  assign push_ok   = push_req && !full && !flush;
  assign pop_ok    = pop_req && !empty && !flush;
  assign push_drop = push_req && full && !flush;
  assign rd_data   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  assert_drop_keeps_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_req) |=> full);
  assert_pair_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !full && !empty && !flush) |=> $stable(level));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/txq_regs.sv
module txq_regs #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  input  logic [CW-1:0] free_slots,
  input  logic        push_drop,
  output logic [15:0] reg_rdata,
  output logic [2:0]  eff_code,
  output logic        req_en,
  output logic        flush_pulse
);
  import txq_pkg::*;

  logic [2:0] wm_code;
  logic       dma_mode, ovf_flag, cfg_flag, cfg_bad;
  logic       clr_ovf, clr_cfg;
  logic       unused_wbits;

  assign unused_wbits = ^reg_wdata[12:5];
  assign cfg_bad      = code_unsafe(wm_code, dma_mode);
  assign eff_code     = cfg_bad ? WM_ALL : wm_code;
  assign flush_pulse  = reg_wr && reg_wdata[BIT_FLUSH];
  assign clr_ovf      = reg_wr && reg_wdata[BIT_OVF];
  assign clr_cfg      = reg_wr && reg_wdata[BIT_CFG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wm_code  <= WM_ALL;
      req_en   <= 1'b0;
      dma_mode <= 1'b0;
      ovf_flag <= 1'b0;
      cfg_flag <= 1'b0;
    end else begin
      if (reg_wr) begin
        wm_code  <= reg_wdata[WM_LSB +: 3];
        req_en   <= reg_wdata[BIT_EN];
        dma_mode <= reg_wdata[BIT_DMA];
      end
      ovf_flag <= (ovf_flag && !clr_ovf) || push_drop;
      cfg_flag <= (cfg_flag && !clr_cfg) || cfg_bad;
    end
  end

  always_comb begin
    reg_rdata                    = '0;
    reg_rdata[WM_LSB +: 3]       = wm_code;
    reg_rdata[FREE_LSB +: 5]     = 5'(free_slots);
    reg_rdata[BIT_CFG]           = cfg_flag;
    reg_rdata[BIT_OVF]           = ovf_flag;
    reg_rdata[BIT_DMA]           = dma_mode;
    reg_rdata[BIT_EN]            = req_en;
  end

  assert_ovf_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovf_flag);
  assert_cfg_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |=> cfg_flag);
  assert_dma_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && wm_code == WM_ONE) |-> (eff_code == WM_ALL));
endmodule

// File: rtl/txq_req.sv
module txq_req #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] free_slots,
  input  logic [2:0]    eff_code,
  input  logic          req_en,
  output logic          xfer_req
);
  import txq_pkg::*;

  localparam logic [CW-1:0] ALL_FREE = CW'(DEPTH);
  logic room_ok;

  assign room_ok = int'(free_slots) >= wm_threshold(eff_code, DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) xfer_req <= 1'b0;
    else        xfer_req <= req_en && room_ok;
  end

  assert_gate_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_en |=> !xfer_req);
  assert_empty_requests_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && free_slots == ALL_FREE) |=> xfer_req);
  assert_full_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slots == '0) |=> !xfer_req);
endmodule

// File: rtl/txq_watermark.sv
module txq_watermark #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          reg_wr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          xfer_req
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] level, free_slots;
  logic          full, empty, push_drop, flush_pulse, req_en;
  logic [2:0]    eff_code;

  assign free_slots = CW'(DEPTH) - level;
  assign rd_valid   = !empty;

  txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_pulse),
    .push_req(push), .pop_req(pop), .wr_data(wr_data),
    .rd_data(rd_data), .level(level), .full(full), .empty(empty),
    .push_drop(push_drop)
  );

  txq_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .free_slots(free_slots), .push_drop(push_drop), .reg_rdata(reg_rdata),
    .eff_code(eff_code), .req_en(req_en), .flush_pulse(flush_pulse)
  );

  txq_req #(.DEPTH(DEPTH)) u_req (
    .clk(clk), .rst_n(rst_n), .free_slots(free_slots),
    .eff_code(eff_code), .req_en(req_en), .xfer_req(xfer_req)
  );

  assert_valid_tracks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !flush_pulse) |=> rd_valid);
endmodule

// File: tb/sim_txq_watermark.sv
module sim_txq_watermark;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push = 1'b0, pop = 1'b0, reg_wr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [15:0]   reg_wdata = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, xfer_req;
  logic [15:0]   reg_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  txq_watermark #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .push(push), .wr_data(wr_data), .pop(pop),
    .rd_data(rd_data), .rd_valid(rd_valid), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req)
  );

  // behavioural reference
  logic [DW-1:0] mq[$];
  int  m_wm, m_en, m_dma, m_ovf, m_cfg, m_req;
  int  sz, thr, nreq;
  bit  bad, m_flush, m_drop;

  function automatic int need_free(input int code);
    if (code == 4) return 12;
    if (code == 5) return 8;
    if (code == 6) return 4;
    if (code == 7) return 1;
    return 16;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_wm = 0; m_en = 0; m_dma = 0; m_ovf = 0; m_cfg = 0; m_req = 0;
    end else begin
      sz      = mq.size();
      bad     = (m_wm >= 1 && m_wm <= 3) || (m_dma == 1 && m_wm == 7);
      thr     = bad ? 16 : need_free(m_wm);
      nreq    = (m_en == 1 && (DEPTH - sz) >= thr) ? 1 : 0;
      m_flush = reg_wr && reg_wdata[4];
      m_drop  = push && (sz == DEPTH) && !m_flush;
      if (m_flush) mq.delete();
      else begin
        if (pop && sz > 0) void'(mq.pop_front());
        if (push && sz < DEPTH) mq.push_back(wr_data);
      end
      m_ovf = ((m_ovf == 1 && !(reg_wr && reg_wdata[2])) || m_drop) ? 1 : 0;
      m_cfg = ((m_cfg == 1 && !(reg_wr && reg_wdata[3])) || bad) ? 1 : 0;
      if (reg_wr) begin
        m_wm  = int'(reg_wdata[15:13]);
        m_en  = int'(reg_wdata[0]);
        m_dma = int'(reg_wdata[1]);
      end
      m_req = nreq;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R1", "rd_valid", int'(rd_valid), (mq.size() > 0) ? 1 : 0);
    if (mq.size() > 0) check("R1", "rd_data order", int'(rd_data), int'(mq[0]));
    check("R2", "free slots", int'(reg_rdata[12:8]), DEPTH - mq.size());
    check("R4", "code field", int'(reg_rdata[15:13]), m_wm);
    check("R3", "overflow flag", int'(reg_rdata[2]), m_ovf);
    check("R5", "config flag", int'(reg_rdata[3]), m_cfg);
    check("R9", "flush reads 0", int'(reg_rdata[4]), 0);
    check("R7", "enable/dma bits", int'(reg_rdata[1:0]), m_dma * 2 + m_en);
    check("R7", "xfer_req", int'(xfer_req), m_req);
  endtask

  // drive, let one edge pass, compare away from the edge
  task automatic step(input bit ps, input logic [DW-1:0] d, input bit pp,
                      input bit rw, input logic [15:0] rd);
    push = ps; wr_data = d; pop = pp; reg_wr = rw; reg_wdata = rd;
    @(posedge clk);
    #1;
    push = 0; pop = 0; reg_wr = 0;
    if (rst_n) compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lvl;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R10: reset state
    check("R10", "ctrl after reset", int'(reg_rdata), 16'h1000);
    check("R10", "req after reset", int'(xfer_req), 0);
    check("R10", "empty after reset", int'(rd_valid), 0);

    // R4: code 100 with request enable, boundary at 12 free
    step(0, '0, 0, 1, 16'h8001);
    for (int i = 0; i < 4; i++) step(1, DW'(8'h10 + i), 0, 0, '0);
    idle(1);
    check("R4", "code 100 at 12 free", int'(xfer_req), 1);
    step(1, 8'h14, 0, 0, '0);
    idle(1);
    check("R4", "code 100 at 11 free", int'(xfer_req), 0);

    // R8: push and pop together keeps occupancy
    lvl = int'(reg_rdata[12:8]);
    step(1, 8'h15, 1, 0, '0);
    check("R8", "pair keeps free count", int'(reg_rdata[12:8]), lvl);

    // R3: fill, then push on full with a pop in the same cycle
    while (reg_rdata[12:8] != 0) step(1, DW'($urandom), 0, 0, '0);
    step(1, 8'hEE, 0, 0, '0);
    check("R3", "overflow flag set", int'(reg_rdata[2]), 1);
    step(1, 8'hEF, 1, 0, '0);
    check("R3", "drop with pop", int'(reg_rdata[12:8]), 1);
    step(0, '0, 0, 1, 16'h8005);
    check("R3", "overflow cleared", int'(reg_rdata[2]), 0);

    // R9: flush beats a push in the same cycle
    step(1, 8'h55, 0, 1, 16'h8011);
    check("R9", "flush empties", int'(rd_valid), 0);
    check("R9", "flush free 16", int'(reg_rdata[12:8]), 16);

    // R6: DMA mode with code 111 falls back to all-empty
    step(0, '0, 0, 1, 16'hE003);
    step(1, 8'h01, 0, 0, '0);
    idle(1);
    check("R6", "dma+111 no request at 15 free", int'(xfer_req), 0);
    check("R6", "dma+111 config flag", int'(reg_rdata[3]), 1);
    step(0, '0, 0, 1, 16'hE009);
    idle(1);
    check("R4", "code 111 request at 15 free", int'(xfer_req), 1);

    // R5: reserved code behaves as all-empty
    step(0, '0, 0, 1, 16'h2009);
    idle(1);
    check("R5", "reserved code no request", int'(xfer_req), 0);
    step(0, '0, 1, 0, '0);
    idle(1);
    check("R5", "reserved code request when empty", int'(xfer_req), 1);

    // random mix; R2 read-only bits are written with random values
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] w;
      bit rw;
      w  = 16'($urandom) & ~16'h0010;
      if ($urandom_range(0, 40) == 0) w[4] = 1'b1;
      rw = ($urandom_range(0, 12) == 0);
      step($urandom_range(0, 2) != 0, DW'($urandom), $urandom_range(0, 2) == 0, rw, w);
    end
    for (int i = 0; i < 300; i++)
      step($urandom_range(0, 3) == 0, DW'($urandom), 1'b1, 1'b0, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule